// File: doc/BRIEF.md
# Masked Time-of-Day Alarm Comparator

This block watches a running BCD time vector and raises an alarm when the time matches a programmed alarm setting. The vector holds hundredths of a second, seconds, minutes, hours, day of the week and date of the month. The timekeeping counters live outside the block. They present the current time on the `tk_*` inputs and pulse `tick` once per hundredth of a second. The comparison is evaluated only on that pulse, so each matching time sets the alarm flag once.

The seconds, minutes and hours alarm bytes each carry a mask flag in bit 7. The day/date alarm byte also carries a mask flag in bit 7, plus a mode selector in bit 6. The sub-second alarm byte has no mask flag. Instead it uses in-band codes: FFh matches every tick, and F0h–F9h compare only the hundredths digit. Software programs the alarm bytes and the interrupt controls through a small register port, and it clears the sticky flag through the same port. The interrupt output is the flag gated by two control bits.

Top module: `tod_alarm_cmp`

## Requirements
- R1: After reset, every alarm byte, both control bits and the alarm flag read as 0, and `alarm_irq` is 0.
- R2: A write with `reg_we`=1 stores `reg_wdata` at `reg_addr`. The addresses are: 0 sub-second alarm, 1 seconds, 2 minutes, 3 hours, 4 day/date, 5 control, 6 status. Addresses 0–4 read back all 8 bits. Address 5 reads back bit 0 (interrupt enable) and bit 1 (interrupt mode), with the other bits 0. Address 6 reads the flag in bit 0, with the other bits 0. Address 7 reads 0.
- R3: For the seconds, minutes and hours alarm bytes, bit 7 = 1 removes the field from the comparison. Bit 7 = 0 makes the field take part: seconds and minutes compare bits 6:0 with `tk_sec`/`tk_min`, and hours compares bits 5:0 with `tk_hour`.
- R4: Bit 7 of the day/date byte masks that field. Bit 6 picks the mode: 0 compares bits 5:0 with `tk_date`, and 1 compares bits 5:0 with the zero-extended `tk_dow`.
- R5: A sub-second alarm byte of FFh matches on every tick. With all four other fields masked, every tick sets the flag.
- R6: A sub-second alarm byte of F0h–F9h compares only its low nibble with the hundredths digit, `tk_sub[3:0]`.
- R7: Any other sub-second alarm byte (00h–99h BCD) compares all 8 bits with `tk_sub` (tenths digit in the high nibble).
- R8: When `tick` is 1 at a rising edge and all enabled fields match, the flag reads 1 after that edge. Without `tick`, a matching time does not set the flag.
- R9: The flag stays at 1 until a status write with bit 0 = 0 clears it. A status write with bit 0 = 1 has no effect. If a set and a clear happen at the same edge, the set wins.
- R10: `alarm_irq` is 1 exactly when the flag, the interrupt enable and the interrupt mode bit are all 1. The flag sets regardless of the two control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| tk_sub | input | 8 | Current time: tenths (high nibble) and hundredths (low nibble), BCD |
| tk_sec | input | 7 | Current seconds, BCD |
| tk_min | input | 7 | Current minutes, BCD |
| tk_hour | input | 6 | Current hours, BCD |
| tk_dow | input | 3 | Current day of week |
| tk_date | input | 6 | Current date of month, BCD |
| tick | input | 1 | Hundredths-of-a-second strobe |
| alarm_irq | output | 1 | Gated alarm interrupt |

## Verification
On every cycle, the assertions check the flag's set, hold and clear rules against the match and write strobes. They also check that the interrupt never asserts without its enable and the flag, and that an all-masked FFh setting sets the flag on any tick. Only the bench scenarios can show the field-level comparison results: which digits each in-band sub-second code really ignores, the day-versus-date selection, and the progressive unmasking of seconds, minutes and hours. These depend on chosen time values matching or just missing.

// File: rtl/tod_alarm_pkg.sv
package tod_alarm_pkg;
    localparam int ALM_DW = 8;
    localparam int ALM_AW = 3;

    localparam logic [ALM_AW-1:0] ADR_SUB  = 3'd0;
    localparam logic [ALM_AW-1:0] ADR_SEC  = 3'd1;
    localparam logic [ALM_AW-1:0] ADR_MIN  = 3'd2;
    localparam logic [ALM_AW-1:0] ADR_HOUR = 3'd3;
    localparam logic [ALM_AW-1:0] ADR_DDAY = 3'd4;
    localparam logic [ALM_AW-1:0] ADR_CTRL = 3'd5;
    localparam logic [ALM_AW-1:0] ADR_STAT = 3'd6;

    localparam int MASK_BIT = 7;
    localparam int MODE_BIT = 6;

    typedef struct packed {
        logic [ALM_DW-1:0] sub;
        logic [ALM_DW-1:0] sec;
        logic [ALM_DW-1:0] min;
        logic [ALM_DW-1:0] hour;
        logic [ALM_DW-1:0] dday;
        logic              ien;
        logic              imode;
    } alm_cfg_t;

    typedef struct packed {
        logic flag;
    } alm_flag_st_t;
endpackage

// File: rtl/tod_alarm_regs.sv
module tod_alarm_regs
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ALM_AW-1:0] wr_addr,
    input  logic [ALM_DW-1:0] wr_data,
    output alm_cfg_t          cfg
);
    alm_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_SUB:  cfg_d.sub  = wr_data;
                ADR_SEC:  cfg_d.sec  = wr_data;
                ADR_MIN:  cfg_d.min  = wr_data;
                ADR_HOUR: cfg_d.hour = wr_data;
                ADR_DDAY: cfg_d.dday = wr_data;
                ADR_CTRL: begin
                    cfg_d.ien   = wr_data[0];
                    cfg_d.imode = wr_data[1];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R2: a byte not addressed by a write keeps its value
    AST_SEC_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_SEC) |=> $stable(cfg.sec)); // R2
endmodule

// File: rtl/tod_alarm_fld.sv
module tod_alarm_fld #(
    parameter int CMP_W = 7
) (
    input  logic             mask_en,
    input  logic [CMP_W-1:0] alm_val,
    input  logic [CMP_W-1:0] cur_val,
    output logic             hit
);
    always_comb begin
        hit = mask_en || (alm_val == cur_val);
    end
endmodule

// File: rtl/tod_alarm_subsec.sv
module tod_alarm_subsec
    import tod_alarm_pkg::*;
(
    input  logic [ALM_DW-1:0] alm,
    input  logic [ALM_DW-1:0] cur,
    output logic              hit
);
    localparam int NIB = ALM_DW / 2;
    localparam logic [NIB-1:0] ESC = '1;

    logic every_tick, digit_only;

    always_comb begin
        every_tick = (alm == '1);
        digit_only = (alm[ALM_DW-1:NIB] == ESC) && !every_tick;
        if (every_tick)
            hit = 1'b1;
        else if (digit_only)
            hit = (alm[NIB-1:0] == cur[NIB-1:0]);
        else
            hit = (alm == cur);
    end
endmodule

// File: rtl/tod_alarm_flag.sv
module tod_alarm_flag
    import tod_alarm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic match,
    input  logic clr_req,
    input  logic ien,
    input  logic imode,
    output logic flag,
    output logic irq
);
    alm_flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_req)
            st_d.flag = 1'b0;
        if (tick && match)
            st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;
    assign irq  = st_q.flag && ien && imode;

    AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && match) |=> flag); // R8
    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !(tick && match)) |=> !flag); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_req) |=> flag); // R9
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !(tick && match)) |=> !flag); // R9
endmodule

// File: rtl/tod_alarm_cmp.sv
module tod_alarm_cmp
    import tod_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ALM_AW-1:0] reg_addr,
    input  logic [ALM_DW-1:0] reg_wdata,
    output logic [ALM_DW-1:0] reg_rdata,
    input  logic [7:0]        tk_sub,
    input  logic [6:0]        tk_sec,
    input  logic [6:0]        tk_min,
    input  logic [5:0]        tk_hour,
    input  logic [2:0]        tk_dow,
    input  logic [5:0]        tk_date,
    input  logic              tick,
    output logic              alarm_irq
);
    localparam int MS_W = 7;
    localparam int HR_W = 6;
    localparam int DD_W = 6;

    alm_cfg_t          cfg;
    logic              sub_hit, sec_hit, min_hit, hour_hit, dd_hit;
    logic              all_hit, clr_req, flag;
    logic [DD_W-1:0]   dd_cur;

    tod_alarm_regs i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .cfg     (cfg)
    );

    tod_alarm_subsec i_sub (
        .alm (cfg.sub),
        .cur (tk_sub),
        .hit (sub_hit)
    );

    tod_alarm_fld #(.CMP_W(MS_W)) i_sec (
        .mask_en (cfg.sec[MASK_BIT]),
        .alm_val (cfg.sec[MS_W-1:0]),
        .cur_val (tk_sec),
        .hit     (sec_hit)
    );

    tod_alarm_fld #(.CMP_W(MS_W)) i_min (
        .mask_en (cfg.min[MASK_BIT]),
        .alm_val (cfg.min[MS_W-1:0]),
        .cur_val (tk_min),
        .hit     (min_hit)
    );

    tod_alarm_fld #(.CMP_W(HR_W)) i_hour (
        .mask_en (cfg.hour[MASK_BIT]),
        .alm_val (cfg.hour[HR_W-1:0]),
        .cur_val (tk_hour),
        .hit     (hour_hit)
    );

    always_comb begin
        if (cfg.dday[MODE_BIT])
            dd_cur = {{(DD_W-3){1'b0}}, tk_dow};
        else
            dd_cur = tk_date;
    end

    tod_alarm_fld #(.CMP_W(DD_W)) i_dday (
        .mask_en (cfg.dday[MASK_BIT]),
        .alm_val (cfg.dday[DD_W-1:0]),
        .cur_val (dd_cur),
        .hit     (dd_hit)
    );

    assign all_hit = sub_hit && sec_hit && min_hit && hour_hit && dd_hit;
    assign clr_req = reg_we && (reg_addr == ADR_STAT) && !reg_wdata[0];

    tod_alarm_flag i_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .match   (all_hit),
        .clr_req (clr_req),
        .ien     (cfg.ien),
        .imode   (cfg.imode),
        .flag    (flag),
        .irq     (alarm_irq)
    );

    always_comb begin
        case (reg_addr)
            ADR_SUB:  reg_rdata = cfg.sub;
            ADR_SEC:  reg_rdata = cfg.sec;
            ADR_MIN:  reg_rdata = cfg.min;
            ADR_HOUR: reg_rdata = cfg.hour;
            ADR_DDAY: reg_rdata = cfg.dday;
            ADR_CTRL: reg_rdata = {{(ALM_DW-2){1'b0}}, cfg.imode, cfg.ien};
            ADR_STAT: reg_rdata = {{(ALM_DW-1){1'b0}}, flag};
            default:  reg_rdata = '0;
        endcase
    end

    AST_FF_ALL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cfg.sub == 8'hFF && cfg.sec[MASK_BIT] && cfg.min[MASK_BIT]
         && cfg.hour[MASK_BIT] && cfg.dday[MASK_BIT]) |=> flag); // R5
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg.ien |-> !alarm_irq); // R10
    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_irq |-> (reg_addr != ADR_STAT || reg_rdata[0])); // R10
endmodule

// File: tb/test_tod_alarm_cmp.sv
module test_tod_alarm_cmp;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] tk_sub = '0;
    logic [6:0] tk_sec = '0;
    logic [6:0] tk_min = '0;
    logic [5:0] tk_hour = '0;
    logic [2:0] tk_dow = '0;
    logic [5:0] tk_date = '0;
    logic       tick = 1'b0;
    logic       alarm_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tod_alarm_cmp i_tod_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tk_sub(tk_sub),
        .tk_sec(tk_sec), .tk_min(tk_min), .tk_hour(tk_hour), .tk_dow(tk_dow),
        .tk_date(tk_date), .tick(tick), .alarm_irq(alarm_irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic chk_flag(input string req, input logic exp);
        logic [7:0] d;
        rd(3'd6, d);
        check(req, d, {7'd0, exp});
    endtask

    task automatic clr_flag();
        wr(3'd6, 8'h00);
    endtask

    task automatic tk(input logic [7:0] s, input logic [6:0] se, input logic [6:0] mi,
                      input logic [5:0] hr, input logic [2:0] dw, input logic [5:0] dt);
        @(negedge clk);
        tk_sub = s; tk_sec = se; tk_min = mi; tk_hour = hr; tk_dow = dw; tk_date = dt;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic mask_all();
        wr(3'd1, 8'h80); wr(3'd2, 8'h80); wr(3'd3, 8'h80); wr(3'd4, 8'h80);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        for (int a = 0; a < 8; a++) begin
            rd(a[2:0], d);
            check("R1 reg after reset", d, 8'h00);
        end
        check("R1 irq after reset", {7'd0, alarm_irq}, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] d;
        wr(3'd0, 8'h5A); rd(3'd0, d); check("R2 sub readback", d, 8'h5A);
        wr(3'd1, 8'hA5); rd(3'd1, d); check("R2 sec readback", d, 8'hA5);
        wr(3'd4, 8'hC3); rd(3'd4, d); check("R2 dday readback", d, 8'hC3);
        wr(3'd5, 8'hFF); rd(3'd5, d); check("R2 ctrl readback", d, 8'h03);
        rd(3'd7, d); check("R2 addr7 reads zero", d, 8'h00);
        wr(3'd6, 8'hFF); chk_flag("R9 writing 1 does not set flag", 1'b0);
        wr(3'd5, 8'h00);
    endtask

    task automatic t_every();
        wr(3'd0, 8'hFF); mask_all();
        tk(8'h37, 7'h12, 7'h34, 6'h05, 3'd2, 6'h11);
        chk_flag("R5 FF sets on any tick", 1'b1);
        clr_flag(); chk_flag("R9 clear by writing 0", 1'b0);
        @(negedge clk); tk_sub = 8'h00;
        repeat (3) @(negedge clk);
        chk_flag("R8 no set without tick", 1'b0);
    endtask

    task automatic t_digit();
        wr(3'd0, 8'hF7); mask_all();
        tk(8'h37, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        chk_flag("R6 Fx hundredths digit match", 1'b1);
        clr_flag();
        tk(8'h97, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        chk_flag("R6 Fx ignores tenths digit", 1'b1);
        clr_flag();
        tk(8'h36, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        chk_flag("R6 Fx digit mismatch", 1'b0);
    endtask

    task automatic t_full();
        wr(3'd0, 8'h42); mask_all();
        tk(8'h42, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        chk_flag("R7 full byte match", 1'b1);
        clr_flag();
        tk(8'h52, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        chk_flag("R7 tenths mismatch", 1'b0);
        tk(8'h43, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        chk_flag("R7 hundredths mismatch", 1'b0);
    endtask

    task automatic t_fields();
        wr(3'd0, 8'h00); mask_all();
        wr(3'd1, 8'h15);
        tk(8'h00, 7'h15, 7'h59, 6'h23, 3'd7, 6'h31);
        chk_flag("R3 seconds match", 1'b1);
        clr_flag();
        tk(8'h00, 7'h16, 7'h59, 6'h23, 3'd7, 6'h31);
        chk_flag("R3 seconds mismatch", 1'b0);
        wr(3'd2, 8'h30);
        tk(8'h00, 7'h15, 7'h31, 6'h23, 3'd7, 6'h31);
        chk_flag("R3 minutes mismatch", 1'b0);
        tk(8'h00, 7'h15, 7'h30, 6'h23, 3'd7, 6'h31);
        chk_flag("R3 minutes match", 1'b1);
        clr_flag();
        wr(3'd3, 8'h12);
        tk(8'h00, 7'h15, 7'h30, 6'h13, 3'd7, 6'h31);
        chk_flag("R3 hours mismatch", 1'b0);
        tk(8'h00, 7'h15, 7'h30, 6'h12, 3'd7, 6'h31);
        chk_flag("R3 hours match", 1'b1);
        clr_flag();
    endtask

    task automatic t_dday();
        wr(3'd4, 8'h43);
        tk(8'h00, 7'h15, 7'h30, 6'h12, 3'd3, 6'h20);
        chk_flag("R4 day-of-week match", 1'b1);
        clr_flag();
        tk(8'h00, 7'h15, 7'h30, 6'h12, 3'd4, 6'h03);
        chk_flag("R4 dow mode ignores date", 1'b0);
        wr(3'd4, 8'h03);
        tk(8'h00, 7'h15, 7'h30, 6'h12, 3'd5, 6'h03);
        chk_flag("R4 date match", 1'b1);
        clr_flag();
        tk(8'h00, 7'h15, 7'h30, 6'h12, 3'd3, 6'h04);
        chk_flag("R4 date mode ignores dow", 1'b0);
    endtask

    task automatic t_sticky();
        wr(3'd0, 8'hFF); mask_all();
        tk(8'h00, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        repeat (4) @(negedge clk);
        chk_flag("R9 flag sticky", 1'b1);
        wr(3'd6, 8'hFF);
        chk_flag("R9 write 1 keeps flag", 1'b1);
        clr_flag();
        @(negedge clk);
        tick = 1'b1; reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h00;
        @(negedge clk);
        tick = 1'b0; reg_we = 1'b0;
        chk_flag("R9 set wins over clear", 1'b1);
        clr_flag();
    endtask

    task automatic t_irq();
        tk(8'h00, 7'h00, 7'h00, 6'h00, 3'd1, 6'h01);
        #1 check("R10 irq off, ctrl 0", {7'd0, alarm_irq}, 8'h00);
        chk_flag("R10 flag sets with irq disabled", 1'b1);
        wr(3'd5, 8'h01); #1 check("R10 enable only", {7'd0, alarm_irq}, 8'h00);
        wr(3'd5, 8'h02); #1 check("R10 mode only", {7'd0, alarm_irq}, 8'h00);
        wr(3'd5, 8'h03); #1 check("R10 both set", {7'd0, alarm_irq}, 8'h01);
        clr_flag(); #1 check("R10 flag cleared", {7'd0, alarm_irq}, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readback();
        t_every();
        t_digit();
        t_full();
        t_fields();
        t_dday();
        t_sticky();
        t_irq();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule